// File: doc/BRIEF.md
# Rate-Adjustable Nanosecond Time Accumulator

This block converts a free-running 32-bit hardware cycle count into a 64-bit nanosecond time value. Each clock it takes the count difference since the previous sample (modulo 2^32), multiplies it by a fixed-point cycles-to-nanoseconds multiplier with 28 fractional bits, and adds the product to an accumulator that keeps those fractional bits. Because an update is made every clock, a single wrap of the raw count is always absorbed correctly.

Software controls the time through three command strobes. It can load an absolute nanosecond value, step the time by a signed 64-bit delta, or trim the rate with a signed request in parts per million carrying 16 fractional bits. A rate request recomputes the multiplier from its nominal value with a rational constant. The constant division runs on a one-bit-per-cycle divider, and a busy flag is raised while that divider works. The tick period is chosen at build time: 8 ns by default, or 10 ns.

Top module: `ns_time_accum`

## Requirements
- R1: During and after reset the time output is 0, the busy flag is 0, the multiplier is nominal, and the current raw count becomes the reference, so no elapsed time is added for it.
- R2: On each clock the time advances by the wrapped count difference times the multiplier, and 28 fractional bits are carried between updates. After a load of T followed by a total count advance D at a constant multiplier m, the time is T + floor(D*m / 2^28), whatever the step sizes.
- R3: The nominal multiplier is 8*2^28 with TICK_10NS=0, which gives 8 ns per count, and 10*2^28 with TICK_10NS=1, which gives 10 ns per count.
- R4: A raw count that wraps past 2^32-1 advances the time by (new - old) mod 2^32 counts.
- R5: A set command makes the output equal the loaded value one clock later. The raw count in that cycle becomes the new reference, and no count difference is added for that cycle.
- R6: A step command adds a signed 64-bit delta, in two's complement, to the time. The count difference of the same cycle is still added, and the rate is not changed.
- R7: An accepted rate request v sets the multiplier to nominal + c when v >= 0, or to nominal - c when v < 0. Here c = floor(|v|*512/15625) in 8 ns mode and c = floor(|v|*128/3125) in 10 ns mode.
- R8: The new multiplier depends only on the nominal value and v, never on the multiplier it replaces.
- R9: Counts elapsed before the multiplier changes are scaled by the old multiplier. Counts elapsed after the change are scaled by the new one.
- R10: A rate request with |v| > 65,536,000 (1,000,000 ppb) is rejected. Busy is not raised and the multiplier is unchanged. |v| = 65,536,000 is accepted.
- R11: Busy is 1 from the clock after a request is accepted until the clock on which the new multiplier takes effect. A rate request made while busy is 1 is ignored.
- R12: When set and step are strobed in the same cycle, the set wins and the step is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| raw_cnt | input | 32 | Free-running cycle count, wraps modulo 2^32 |
| set_valid | input | 1 | Load set_ns as the absolute time |
| set_ns | input | 64 | Absolute time value in nanoseconds |
| step_valid | input | 1 | Add step_ns to the time |
| step_ns | input | 64 | Signed phase step in nanoseconds |
| adj_valid | input | 1 | Rate request strobe |
| adj_sppm | input | 32 | Signed rate request in ppm, 16 fractional bits |
| adj_busy | output | 1 | Rate request in progress |
| now_ns | output | 64 | Current time in nanoseconds |

## Verification
A wrong multiplier or a lost fractional remainder does not show on the first update. It shows at the ports only after the count advance is large enough for the error to pass a whole nanosecond. The bench therefore measures the rate over advances of up to a million counts and across many uneven step sizes. A wrong reference after a load or a wrap shows one clock later as an offset of whole counts times the tick. A divider fault shows as a busy window of the wrong length, or as a rate that differs in its low digits from the exact quotient.

// File: rtl/nsacc_pkg.sv
`timescale 1ns/1ps
// Package: shared widths and build-time constants for the nanosecond accumulator.
// Assumes the raw count and the multiplier are both 32 bits wide.
package nsacc_pkg;
    localparam int RAW_W  = 32;
    localparam int FRAC_W = 28;
    localparam int MULT_W = 32;
    localparam int TIME_W = 64;
    localparam int ACC_W  = TIME_W + FRAC_W;
    localparam int ADJ_W  = 32;
    localparam int LIMIT_PPM = 1000;
    localparam logic [ADJ_W-1:0] ADJ_LIMIT = ADJ_W'(LIMIT_PPM) << 16;

    // Nominal cycles-to-ns multiplier for the selected tick
    function automatic logic [MULT_W-1:0] nominal_mult(input bit t10);
        return t10 ? (MULT_W'(10) << FRAC_W) : (MULT_W'(8) << FRAC_W);
    endfunction

    // Power-of-two numerator of the rate constant
    function automatic int num_shift(input bit t10);
        return t10 ? 7 : 9;
    endfunction

    // Odd denominator of the rate constant
    function automatic int rate_den(input bit t10);
        return t10 ? 3125 : 15625;
    endfunction
endpackage

// File: rtl/nsacc_const_div.sv
`timescale 1ns/1ps
// Module: restoring divider by a constant, one quotient bit per clock.
// Assumes start is only raised while busy is low, and that DEN < 2^(REM_W-1).
// done pulses for one clock once quot holds the final quotient.
module nsacc_const_div #(
    parameter int DIV_W = 41,
    parameter int REM_W = 16,
    parameter int DEN   = 15625,
    parameter int QUO_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DIV_W-1:0] dividend,
    output logic             busy,
    output logic             done,
    output logic [QUO_W-1:0] quot
);
    localparam int CNT_W = $clog2(DIV_W + 1);

    logic [DIV_W-1:0] q_sh;
    logic [REM_W-1:0] rem;
    logic [REM_W-1:0] rem_nxt;
    logic [REM_W:0]   trial;
    logic             take;
    logic [CNT_W-1:0] cnt;

    // Trial subtraction of the divisor from the shifted remainder
    always_comb begin
        trial   = {rem, q_sh[DIV_W-1]};
        take    = trial >= (REM_W+1)'(DEN);
        rem_nxt = take ? REM_W'(trial - (REM_W+1)'(DEN)) : REM_W'(trial);
    end

    // Iteration state: load on start, shift one bit per clock while busy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            done <= 1'b0;
            cnt  <= '0;
            q_sh <= '0;
            rem  <= '0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                q_sh <= dividend;
                rem  <= '0;
                cnt  <= CNT_W'(DIV_W);
                busy <= 1'b1;
            end else if (busy) begin
                rem  <= rem_nxt;
                q_sh <= {q_sh[DIV_W-2:0], take};
                cnt  <= cnt - 1'b1;
                if (cnt == CNT_W'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign quot = q_sh[QUO_W-1:0];
endmodule

// File: rtl/nsacc_rate_ctrl.sv
`timescale 1ns/1ps
// Module: rate trim. Range-checks a signed scaled-ppm request, divides its
// magnitude by the rational constant, and rebuilds the multiplier from nominal.
// Assumes requests are strobes; a request while busy is dropped.
module nsacc_rate_ctrl
    import nsacc_pkg::*;
#(
    parameter bit TICK_10NS = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adj_valid,
    input  logic [ADJ_W-1:0]  adj_sppm,
    output logic              busy,
    output logic [MULT_W-1:0] mult
);
    localparam logic [MULT_W-1:0] NOM = nominal_mult(TICK_10NS);
    localparam int NUM_SH = num_shift(TICK_10NS);
    localparam int DEN    = rate_den(TICK_10NS);
    localparam int DIV_W  = ADJ_W + NUM_SH;

    logic [ADJ_W-1:0]  mag;
    logic              in_range;
    logic              accept;
    logic              neg_q;
    logic              div_busy;
    logic              div_done;
    logic [MULT_W-1:0] corr;
    logic [DIV_W-1:0]  dividend;

    // Magnitude of the request and range test against the limit
    always_comb begin
        mag      = adj_sppm[ADJ_W-1] ? (~adj_sppm + 1'b1) : adj_sppm;
        in_range = mag <= ADJ_LIMIT;
        dividend = DIV_W'(mag) << NUM_SH;
    end

    assign busy   = div_busy | div_done;
    assign accept = adj_valid && !busy && in_range;

    nsacc_const_div #(
        .DIV_W (DIV_W),
        .REM_W (16),
        .DEN   (DEN),
        .QUO_W (MULT_W)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .dividend (dividend),
        .busy     (div_busy),
        .done     (div_done),
        .quot     (corr)
    );

    // Sign capture on accept; multiplier rebuilt from nominal on completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            neg_q <= 1'b0;
            mult  <= NOM;
        end else begin
            if (accept) begin
                neg_q <= adj_sppm[ADJ_W-1];
            end
            if (div_done) begin
                mult <= neg_q ? (NOM - corr) : (NOM + corr);
            end
        end
    end
endmodule

// File: rtl/nsacc_time_accum.sv
`timescale 1ns/1ps
// Module: fixed-point time accumulator. Adds the wrapped count difference
// times the multiplier every clock and keeps 28 fractional nanosecond bits.
// Assumes the raw count moves by less than 2^32 between clocks.
module nsacc_time_accum
    import nsacc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RAW_W-1:0]  raw_cnt,
    input  logic [MULT_W-1:0] mult,
    input  logic              set_valid,
    input  logic [TIME_W-1:0] set_ns,
    input  logic              step_valid,
    input  logic [TIME_W-1:0] step_ns,
    output logic [TIME_W-1:0] now_ns
);
    logic [RAW_W-1:0]        prev_cnt;
    logic [RAW_W-1:0]        delta;
    logic [RAW_W+MULT_W-1:0] prod;
    logic [ACC_W-1:0]        step_fx;
    logic [ACC_W-1:0]        acc;

    // Wrapped count difference, its scaled value, and the fixed-point step
    always_comb begin
        delta   = raw_cnt - prev_cnt;
        prod    = (RAW_W+MULT_W)'(delta) * (RAW_W+MULT_W)'(mult);
        step_fx = step_valid ? {step_ns, {FRAC_W{1'b0}}} : '0;
    end

    // Accumulator update: a load re-references, otherwise add product and step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc      <= '0;
            prev_cnt <= raw_cnt;
        end else begin
            prev_cnt <= raw_cnt;
            if (set_valid) begin
                acc <= {set_ns, {FRAC_W{1'b0}}};
            end else begin
                acc <= acc + ACC_W'(prod) + step_fx;
            end
        end
    end

    assign now_ns = acc[ACC_W-1:FRAC_W];
endmodule

// File: rtl/ns_time_accum.sv
`timescale 1ns/1ps
// Module: top of the rate-adjustable nanosecond time accumulator.
// Joins the rate trim and the accumulator. The multiplier change and the
// accumulator update share one edge, so counts before it use the old rate.
module ns_time_accum
    import nsacc_pkg::*;
#(
    parameter bit TICK_10NS = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RAW_W-1:0]  raw_cnt,
    input  logic              set_valid,
    input  logic [TIME_W-1:0] set_ns,
    input  logic              step_valid,
    input  logic [TIME_W-1:0] step_ns,
    input  logic              adj_valid,
    input  logic [ADJ_W-1:0]  adj_sppm,
    output logic              adj_busy,
    output logic [TIME_W-1:0] now_ns
);
    logic [MULT_W-1:0] mult_q;

    nsacc_rate_ctrl #(
        .TICK_10NS (TICK_10NS)
    ) u_rate (
        .clk       (clk),
        .rst_n     (rst_n),
        .adj_valid (adj_valid),
        .adj_sppm  (adj_sppm),
        .busy      (adj_busy),
        .mult      (mult_q)
    );

    nsacc_time_accum u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .raw_cnt    (raw_cnt),
        .mult       (mult_q),
        .set_valid  (set_valid),
        .set_ns     (set_ns),
        .step_valid (step_valid),
        .step_ns    (step_ns),
        .now_ns     (now_ns)
    );
endmodule

// File: rtl/nsacc_checker.sv
`timescale 1ns/1ps
// Checker: temporal properties of the accumulator, bound to the top module.
module nsacc_checker
    import nsacc_pkg::*;
#(
    parameter bit TICK_10NS = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [RAW_W-1:0]  raw_cnt,
    input logic              set_valid,
    input logic [TIME_W-1:0] set_ns,
    input logic              step_valid,
    input logic              adj_valid,
    input logic [ADJ_W-1:0]  adj_sppm,
    input logic              adj_busy,
    input logic [MULT_W-1:0] mult,
    input logic [TIME_W-1:0] now_ns
);
    localparam longint NOM  = longint'(nominal_mult(TICK_10NS));
    localparam longint MAXC = (longint'(ADJ_LIMIT) << num_shift(TICK_10NS)) / rate_den(TICK_10NS);

    logic [ADJ_W-1:0] req_mag;
    assign req_mag = adj_sppm[ADJ_W-1] ? (~adj_sppm + 1'b1) : adj_sppm;

    assert_set_loads_R5: assert property (@(posedge clk) disable iff (!rst_n)
        set_valid |=> now_ns == $past(set_ns));

    assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_valid && !step_valid && raw_cnt == $past(raw_cnt)) |=> $stable(now_ns));

    assert_busy_after_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (adj_valid && !adj_busy && req_mag <= ADJ_LIMIT) |=> adj_busy);

    assert_mult_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (adj_busy && $past(adj_busy)) |-> $stable(mult));

    assert_reject_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (adj_valid && !adj_busy && req_mag > ADJ_LIMIT) |=> (!adj_busy && $stable(mult)));

    assert_mult_bounds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (longint'(mult) >= NOM - MAXC) && (longint'(mult) <= NOM + MAXC));
endmodule

bind ns_time_accum nsacc_checker #(.TICK_10NS(TICK_10NS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .raw_cnt    (raw_cnt),
    .set_valid  (set_valid),
    .set_ns     (set_ns),
    .step_valid (step_valid),
    .adj_valid  (adj_valid),
    .adj_sppm   (adj_sppm),
    .adj_busy   (adj_busy),
    .mult       (mult_q),
    .now_ns     (now_ns)
);

// File: tb/sim_ns_time_accum.sv
`timescale 1ns/1ps
module sim_ns_time_accum;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] raw = 32'd1000;
    logic        set_v = 1'b0, step_v = 1'b0, adj_v = 1'b0;
    logic [63:0] set_val = '0, step_val = '0;
    logic [31:0] adj_val = '0;
    logic        busy0, busy1;
    logic [63:0] t0, t1;

    int total = 0;
    int bad   = 0;

    localparam logic [31:0] NOM0 = 32'd8 << 28;
    localparam logic [31:0] NOM1 = 32'd10 << 28;

    logic [31:0]  m0 = NOM0, m1 = NOM1;
    logic [63:0]  base = '0;
    logic [127:0] sum0 = '0, sum1 = '0;

    always #2.5 clk = ~clk;

    ns_time_accum #(.TICK_10NS(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .raw_cnt(raw),
        .set_valid(set_v), .set_ns(set_val),
        .step_valid(step_v), .step_ns(step_val),
        .adj_valid(adj_v), .adj_sppm(adj_val),
        .adj_busy(busy0), .now_ns(t0));

    ns_time_accum #(.TICK_10NS(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .raw_cnt(raw),
        .set_valid(set_v), .set_ns(set_val),
        .step_valid(step_v), .step_ns(step_val),
        .adj_valid(adj_v), .adj_sppm(adj_val),
        .adj_busy(busy1), .now_ns(t1));

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    task automatic report();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    // Time the requirements predict for both instances
    task automatic chk_time(input string tag);
        chk({tag, " 8ns"},  t0, base + 64'(sum0 >> 28));
        chk({tag, " 10ns"}, t1, base + 64'(sum1 >> 28));
    endtask

    function automatic logic [31:0] new_mult(input logic [31:0] nom, input logic [31:0] v,
                                             input int sh, input int den);
        logic [63:0] mag;
        logic [63:0] c;
        mag = v[31] ? 64'(-$signed(v)) : 64'(v);
        c   = (mag << sh) / 64'(den);
        return v[31] ? nom - 32'(c) : nom + 32'(c);
    endfunction

    task automatic advance(input logic [31:0] d);
        raw  = raw + d;
        sum0 = sum0 + 128'(d) * 128'(m0);
        sum1 = sum1 + 128'(d) * 128'(m1);
        @(negedge clk);
    endtask

    task automatic do_set(input logic [63:0] t, input logic [31:0] r);
        set_v = 1'b1; set_val = t; raw = r;
        @(negedge clk);
        set_v = 1'b0;
        base = t; sum0 = '0; sum1 = '0;
    endtask

    task automatic do_step(input logic [63:0] s, input logic [31:0] d);
        step_v = 1'b1; step_val = s;
        base = base + s;
        advance(d);
        step_v = 1'b0;
    endtask

    task automatic do_adj(input logic [31:0] v);
        adj_v = 1'b1; adj_val = v;
        @(negedge clk);
        adj_v = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 200 && (busy0 || busy1); i++) @(negedge clk);
    endtask

    // Rate measurement from a fresh load over uneven steps
    task automatic rate_check(input string tag);
        do_set(64'd5_000_000_000, raw);
        for (int k = 0; k < 10; k++) advance(32'(100_000 + k * 1237));
        chk_time(tag);
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset time 8ns", t0, 64'd0);
        chk("R1 reset time 10ns", t1, 64'd0);
        chk("R1 reset busy", {62'd0, busy1, busy0}, 64'd0);
        // R1: the raw count at reset is the reference; R3: nominal tick
        advance(32'd3);
        chk_time("R3 nominal tick after reset");

        do_set(64'd1_000_000_000, 32'd5000);
        chk_time("R5 set loads value");
        for (int k = 1; k <= 30; k++) begin
            advance(32'(k * 7919 + 3));
            chk_time("R2 sweep");
        end
        advance(32'h7FFF_FFFF);
        chk_time("R2 large delta");

        do_set(64'd777, 32'hFFFF_FFF0);
        advance(32'h20);
        chk_time("R4 wrap");

        do_step(-64'sd500, 32'd0);
        chk_time("R6 negative step");
        do_step(64'd1234, 32'd2);
        chk_time("R6 step with counts");

        set_v = 1'b1; set_val = 64'd42; step_v = 1'b1; step_val = 64'd9999; raw = raw + 32'd5;
        @(negedge clk);
        set_v = 1'b0; step_v = 1'b0;
        base = 64'd42; sum0 = '0; sum1 = '0;
        chk_time("R12 set beats step");

        // R9: counts before the change at the old rate, after it at the new rate
        do_set(64'd0, raw);
        advance(32'd1_000_000);
        chk_time("R9 before adjust");
        do_adj(32'd123_457);
        chk("R11 busy after accept", {62'd0, busy1, busy0}, 64'd3);
        do_adj(32'hFFF0_BDC0);
        wait_idle();
        m0 = new_mult(NOM0, 32'd123_457, 9, 15625);
        m1 = new_mult(NOM1, 32'd123_457, 7, 3125);
        advance(32'd1_000_000);
        chk_time("R9 R11 after adjust, busy request ignored");
        rate_check("R7 positive rate");

        do_adj(32'hFFF0_BDC0);
        wait_idle();
        m0 = new_mult(NOM0, 32'hFFF0_BDC0, 9, 15625);
        m1 = new_mult(NOM1, 32'hFFF0_BDC0, 7, 3125);
        rate_check("R8 negative rate from nominal");

        do_adj(32'd65_536_000);
        wait_idle();
        m0 = new_mult(NOM0, 32'd65_536_000, 9, 15625);
        m1 = new_mult(NOM1, 32'd65_536_000, 7, 3125);
        rate_check("R10 limit accepted");

        do_adj(32'd65_536_001);
        chk("R10 reject no busy", {62'd0, busy1, busy0}, 64'd0);
        do_adj(32'hFC17_FFFF);
        chk("R10 reject neg no busy", {62'd0, busy1, busy0}, 64'd0);
        rate_check("R10 rate unchanged after reject");

        do_adj(32'd0);
        wait_idle();
        m0 = NOM0; m1 = NOM1;
        rate_check("R8 zero request restores nominal");

        report();
        $finish;
    end
endmodule